// File: doc/BRIEF.md
# Four-Cell Configurable Logic Cluster

The block is one programmable logic cluster built from four identical cells. Each cell holds a 16-entry lookup table, one storage element that acts either as a rising-edge flip-flop or as a transparent latch, and a link into a chain that runs through all four cells. That chain can ripple an arithmetic carry or act as a cascade that ANDs lookup results, which lets the cluster decode wide input functions. Each cell also passes its direct data input straight to a feedthrough output. This path works alongside the lookup and the storage element, and uses neither.

A configuration word sets what the cluster does. It holds the four truth tables, the output choice for each cell, the data source and storage mode of each storage element, and one chain-mode bit. The word is captured while the config-enable input is high. During operation the cluster takes 20 data inputs, 5 per cell, and drives 12 data outputs, 3 per cell. It also has one chain input and one chain output, plus clock, clock enable and an asynchronous clear. The even/odd cell pairs (0,1) and (2,3) can each be made to act as one 5-input function.

Top module: `logic_cluster4`

## Requirements
- R1: On a rising clock edge with cfg_en high, the configuration register takes cfg_word; with cfg_en low it keeps its value whatever cfg_word holds. While rst_n is low the register is all zeros. Cell i owns bits [20i+19:20i]: [20i+15:20i] is its truth table, [20i+17:20i+16] is its output select, [20i+18] is its data select and [20i+19] is its latch-mode bit. Bit 80 selects cascade mode (1) or carry mode (0).
- R2: Cell i reads its lookup inputs {F4,F3,F2,F1} = f_in[5i+3:5i], with F1 as bit 0. With output select 0, x_out[i] is the truth-table bit at index {F4,F3,F2,F1}.
- R3: do_out[i] always equals the direct input DI = f_in[5i+4], whatever the lookup, storage and chain settings.
- R4: With the latch-mode bit at 0, q_out[i] takes the cell's storage data on a rising clock edge when ce is high. It holds its value while ce is low.
- R5: With the latch-mode bit at 1, q_out[i] follows the storage data while clk is high and holds while clk is low. The ce input has no effect in this mode.
- R6: A high clr forces every q_out bit to 0 at once, in both storage modes. It overrides ce and the latch gate.
- R7: With the data-select bit at 0, the storage data is the cell's x_out value; with it at 1, the storage data is DI.
- R8: In carry mode, each cell's carry-out is (F1 AND F2) OR (carry-in AND (F1 XOR F2)). Cell 0 takes chain_in as its carry-in and chain_out is the carry-out of cell 3. Output select 1 gives lookup XOR carry-in, which is the sum bit when the table is 16'h6666.
- R9: In cascade mode, each cell's chain-out is its lookup output AND its chain-in, so chain_out is chain_in AND all four lookup outputs. Output select 3 gives the cell's own chain-out, in either chain mode.
- R10: Output select 2 gives the pair function for the cell's pair (0,1) or (2,3). It is the odd cell's lookup output when the odd cell's DI is 1, and the even cell's lookup output when that DI is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the gate of storage elements in latch mode |
| rst_n | input | 1 | Active-low reset of the configuration register |
| cfg_en | input | 1 | Allows the configuration register to load |
| cfg_word | input | 81 | Configuration value to load |
| ce | input | 1 | Clock enable for the flip-flop mode |
| clr | input | 1 | Asynchronous clear of all storage elements |
| f_in | input | 20 | Five inputs per cell: lookup inputs and DI |
| chain_in | input | 1 | Carry or cascade value entering cell 0 |
| x_out | output | 4 | Selected function output of each cell |
| q_out | output | 4 | Storage element output of each cell |
| do_out | output | 4 | Direct feedthrough output of each cell |
| chain_out | output | 1 | Carry or cascade value leaving cell 3 |

## Verification
The lookup is driven with pseudo-random inputs under four unlike tables (AND, OR, parity and an irregular one), so a swapped index bit or a wrong cell mapping shows up as a mismatch. The carry chain is run with its propagate tables and random operands. It is also run with all-ones operands and carry-in, the full ripple case, and with all zeros, which tells a correct majority apart from a plain OR or AND. The cascade is run with all inputs high and then with a single input low, so a break at any one cell is exposed. The storage element is run with ce toggling, with data that changes while the latch gate is low, and with clear held across both clock phases, which separates flip-flop capture, latch hold and clear priority.

// File: rtl/lc_pkg.sv
package lc_pkg;

    localparam int LC_K          = 4;
    localparam int LC_TBL_W      = 1 << LC_K;
    localparam int LC_CELL_IN    = LC_K + 1;
    localparam int LC_CELL_CFG_W = LC_TBL_W + 4;

    typedef enum logic [1:0] {
        XS_LUT   = 2'd0,
        XS_SUM   = 2'd1,
        XS_PAIR  = 2'd2,
        XS_CHAIN = 2'd3
    } xsel_e;

    typedef struct packed {
        logic                latch;
        logic                dsel;
        xsel_e               xsel;
        logic [LC_TBL_W-1:0] tbl;
    } cell_cfg_t;

endpackage

// File: rtl/lc_cfg_reg.sv
module lc_cfg_reg #(
    parameter int W = 81
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_en,
    input  logic [W-1:0] cfg_word,
    output logic [W-1:0] cfg_o
);

    logic [W-1:0] cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_en) cfg_d = cfg_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;

    // R1
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> $stable(cfg_o));

    // R1
    cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> (cfg_o == $past(cfg_word)));

endmodule

// File: rtl/lc_cell.sv
module lc_cell
    import lc_pkg::*;
(
    input  cell_cfg_t       cfg_i,
    input  logic [LC_K-1:0] f_i,
    input  logic            di_i,
    input  logic            c_i,
    input  logic            cascade_i,
    input  logic            pair_i,
    output logic            lut_o,
    output logic            c_o,
    output logic            x_o,
    output logic            d_o
);

    logic gen_w, prop_w;

    always_comb begin
        lut_o  = cfg_i.tbl[f_i];
        gen_w  = f_i[0] & f_i[1];
        prop_w = f_i[0] ^ f_i[1];
        if (cascade_i) c_o = lut_o & c_i;
        else           c_o = gen_w | (c_i & prop_w);
    end

    always_comb begin
        x_o = lut_o;
        case (cfg_i.xsel)
            XS_LUT:   x_o = lut_o;
            XS_SUM:   x_o = lut_o ^ c_i;
            XS_PAIR:  x_o = pair_i;
            XS_CHAIN: x_o = c_o;
            default:  x_o = lut_o;
        endcase
        d_o = cfg_i.dsel ? di_i : x_o;
    end

endmodule

// File: rtl/lc_store.sv
module lc_store (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic ce,
    input  logic latch_mode,
    input  logic d_i,
    output logic q_o
);

    logic ff_d, ff_q;
    logic lat_q;

    always_comb begin
        ff_d = ff_q;
        if (ce) ff_d = d_i;
    end

    always_ff @(posedge clk or posedge clr) begin
        if (clr) ff_q <= 1'b0;
        else     ff_q <= ff_d;
    end

    always_latch begin
        if (clr)      lat_q = 1'b0;
        else if (clk) lat_q = d_i;
    end

    assign q_o = latch_mode ? lat_q : ff_q;

    // R6
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> (q_o == 1'b0));

    // R4
    ff_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_mode && !ce && !clr) |=> (latch_mode || clr || $stable(q_o)));

    // R4
    ff_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_mode && ce && !clr) |=> (latch_mode || clr || q_o == $past(d_i)));

    // R5
    latch_follow_chk: assert property (@(negedge clk) disable iff (!rst_n)
        (latch_mode && !clr) |-> (q_o == d_i));

endmodule

// File: rtl/logic_cluster4.sv
module logic_cluster4
    import lc_pkg::*;
#(
    parameter int N_CELLS = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 cfg_en,
    input  logic [N_CELLS*LC_CELL_CFG_W:0]       cfg_word,
    input  logic                                 ce,
    input  logic                                 clr,
    input  logic [N_CELLS*LC_CELL_IN-1:0]        f_in,
    input  logic                                 chain_in,
    output logic [N_CELLS-1:0]                   x_out,
    output logic [N_CELLS-1:0]                   q_out,
    output logic [N_CELLS-1:0]                   do_out,
    output logic                                 chain_out
);

    localparam int CELL_W = LC_CELL_CFG_W;
    localparam int CFG_W  = N_CELLS * CELL_W + 1;
    localparam int N_PAIR = N_CELLS / 2;

    logic [CFG_W-1:0]   cfg_q;
    logic               cascade;
    logic [N_CELLS:0]   chain_w;
    logic [N_CELLS-1:0] lut_w, d_w, di_w;
    logic [N_PAIR-1:0]  pair_w;

    lc_cfg_reg #(.W(CFG_W)) cfg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_en   (cfg_en),
        .cfg_word (cfg_word),
        .cfg_o    (cfg_q)
    );

    assign cascade    = cfg_q[CFG_W-1];
    assign chain_w[0] = chain_in;
    assign chain_out  = chain_w[N_CELLS];

    for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
        assign pair_w[p] = di_w[2*p+1] ? lut_w[2*p+1] : lut_w[2*p];
    end

    for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
        cell_cfg_t cc;
        assign cc      = cell_cfg_t'(cfg_q[i*CELL_W +: CELL_W]);
        assign di_w[i] = f_in[i*LC_CELL_IN + LC_K];

        lc_cell cell_i (
            .cfg_i     (cc),
            .f_i       (f_in[i*LC_CELL_IN +: LC_K]),
            .di_i      (di_w[i]),
            .c_i       (chain_w[i]),
            .cascade_i (cascade),
            .pair_i    (pair_w[i/2]),
            .lut_o     (lut_w[i]),
            .c_o       (chain_w[i+1]),
            .x_o       (x_out[i]),
            .d_o       (d_w[i])
        );

        lc_store store_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .clr        (clr),
            .ce         (ce),
            .latch_mode (cc.latch),
            .d_i        (d_w[i]),
            .q_o        (q_out[i])
        );

        assign do_out[i] = di_w[i];
    end

    logic [N_CELLS-1:0] op_a, op_b;
    logic [N_CELLS:0]   add_ref;

    always_comb begin
        for (int k = 0; k < N_CELLS; k++) begin
            op_a[k] = f_in[k*LC_CELL_IN];
            op_b[k] = f_in[k*LC_CELL_IN + 1];
        end
        add_ref = {1'b0, op_a} + {1'b0, op_b} + {{N_CELLS{1'b0}}, chain_in};
    end

    // R8
    carry_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cascade |-> (chain_out == add_ref[N_CELLS]));

    // R9
    cascade_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cascade |-> (chain_out == (chain_in & (&lut_w))));

endmodule

// File: tb/logic_cluster4_tb_top.sv
module logic_cluster4_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int N    = 4;
    localparam int CW   = 20;
    localparam int CFGW = N * CW + 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_en = 1'b0;
    logic [CFGW-1:0] cfg_word = '0;
    logic            ce = 1'b0;
    logic            clr = 1'b1;
    logic [5*N-1:0]  f_in = '0;
    logic            chain_in = 1'b0;
    logic [N-1:0]    x_out, q_out, do_out;
    logic            chain_out;

    logic_cluster4 #(.N_CELLS(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_word(cfg_word),
        .ce(ce), .clr(clr), .f_in(f_in), .chain_in(chain_in),
        .x_out(x_out), .q_out(q_out), .do_out(do_out), .chain_out(chain_out)
    );

    always #2.5 clk = ~clk;

    int              total = 0;
    int              bad = 0;
    logic [CFGW-1:0] cfg_m = '0;
    logic [N-1:0]    q_m = '0;
    logic [31:0]     rs = 32'h1234_5678;

    function automatic logic [19:0] rnd();
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 17);
        rs = rs ^ (rs << 5);
        return rs[19:0];
    endfunction

    function automatic logic lut_m(int i);
        int idx = int'(f_in[i*5 +: 4]);
        return cfg_m[i*CW + idx];
    endfunction

    function automatic logic di_m(int i);
        return f_in[i*5 + 4];
    endfunction

    function automatic logic cin_m(int i);
        if (cfg_m[CFGW-1]) begin
            logic v = chain_in;
            for (int j = 0; j < i; j++) v = v & lut_m(j);
            return v;
        end else begin
            int a = 0;
            int b = 0;
            for (int j = 0; j < i; j++) begin
                a = a + (int'(f_in[j*5]) << j);
                b = b + (int'(f_in[j*5+1]) << j);
            end
            return 1'(((a + b + int'(chain_in)) >> i) & 1);
        end
    endfunction

    function automatic logic x_m(int i);
        int xs = int'(cfg_m[i*CW+16 +: 2]);
        int p = i / 2;
        case (xs)
            0: return lut_m(i);
            1: return lut_m(i) ^ cin_m(i);
            2: return di_m(2*p+1) ? lut_m(2*p+1) : lut_m(2*p);
            default: return cin_m(i+1);
        endcase
    endfunction

    function automatic logic d_m(int i);
        return cfg_m[i*CW+18] ? di_m(i) : x_m(i);
    endfunction

    function automatic logic [CFGW-1:0] pack(logic [15:0] t0, logic [15:0] t1,
                                            logic [15:0] t2, logic [15:0] t3,
                                            logic [1:0] xs, logic ds, logic lt,
                                            logic casc);
        logic [CFGW-1:0] w;
        logic [15:0] t [4];
        t[0] = t0; t[1] = t1; t[2] = t2; t[3] = t3;
        w = '0;
        for (int i = 0; i < N; i++) w[i*CW +: CW] = {lt, ds, xs, t[i]};
        w[CFGW-1] = casc;
        return w;
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare(string req);
        logic [N-1:0] ex, dx;
        for (int i = 0; i < N; i++) begin
            ex[i] = x_m(i);
            dx[i] = di_m(i);
        end
        chk(req, "x_out", 32'(x_out), 32'(ex));
        chk(req, "q_out", 32'(q_out), 32'(q_m));
        chk("R3", "do_out", 32'(do_out), 32'(dx));
        chk(req, "chain_out", 32'(chain_out), 32'(cin_m(N)));
    endtask

    task automatic step(string req, logic en, logic [CFGW-1:0] w, logic ce_v,
                        logic clr_v, logic [19:0] f_v, logic cin_v);
        logic [N-1:0] nq;
        @(negedge clk);
        #0.5;
        cfg_en = en; cfg_word = w; ce = ce_v; clr = clr_v;
        f_in = f_v; chain_in = cin_v;
        if (clr_v) q_m = '0;
        @(posedge clk);
        nq = q_m;
        for (int i = 0; i < N; i++)
            if (!cfg_m[i*CW+19] && ce_v && !clr_v) nq[i] = d_m(i);
        q_m = nq;
        if (en) cfg_m = w;
        for (int i = 0; i < N; i++)
            if (cfg_m[i*CW+19] && !clr_v) q_m[i] = d_m(i);
        if (clr_v) q_m = '0;
        #1.25;
        compare(req);
    endtask

    task automatic hold_check(logic [19:0] f_v);
        @(negedge clk);
        #0.5;
        f_in = f_v;
        #1;
        chk("R5", "q_out while gate low", 32'(q_out), 32'(q_m));
    endtask

    task automatic load(logic [CFGW-1:0] w);
        step("R1", 1'b1, w, 1'b0, 1'b1, rnd(), 1'b0);
    endtask

    initial begin
        #1000000;
        total++;
        bad++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state, all tables zero
        for (int k = 0; k < 3; k++) step("R1", 1'b0, '0, 1'b1, 1'b0, rnd(), 1'b0);

        // R2, R4, R7: lookup with flip-flops capturing x_out
        load(pack(16'h8000, 16'hFFFE, 16'h6996, 16'hA5C3, 2'd0, 1'b0, 1'b0, 1'b0));
        for (int k = 0; k < 20; k++) step("R2", 1'b0, '0, 1'b1, 1'b0, rnd(), 1'b0);
        step("R2", 1'b0, '0, 1'b1, 1'b0, 20'hFFFFF, 1'b0);
        step("R2", 1'b0, '0, 1'b1, 1'b0, 20'h00000, 1'b0);

        // R1: writes ignored with cfg_en low
        for (int k = 0; k < 3; k++) step("R1", 1'b0, '1, 1'b1, 1'b0, rnd(), 1'b1);

        // R4: clock enable toggling
        for (int k = 0; k < 12; k++) step("R4", 1'b0, '0, k[0], 1'b0, rnd(), 1'b0);

        // R6: clear in flip-flop mode overrides ce
        step("R6", 1'b0, '0, 1'b1, 1'b1, rnd(), 1'b0);
        step("R6", 1'b0, '0, 1'b1, 1'b1, rnd(), 1'b0);
        step("R6", 1'b0, '0, 1'b1, 1'b0, 20'hFFFFF, 1'b0);

        // R7: storage data from DI
        load(pack(16'h0000, 16'h0000, 16'h0000, 16'h0000, 2'd0, 1'b1, 1'b0, 1'b0));
        for (int k = 0; k < 10; k++) step("R7", 1'b0, '0, 1'b1, 1'b0, rnd(), 1'b0);

        // R5: latch mode, ce ignored, holds while gate low
        load(pack(16'h1234, 16'h5678, 16'h9ABC, 16'hDEF0, 2'd0, 1'b1, 1'b1, 1'b0));
        for (int k = 0; k < 10; k++) begin
            step("R5", 1'b0, '0, k[0], 1'b0, rnd(), 1'b0);
            hold_check(rnd());
        end

        // R6: clear in latch mode held across the high phase
        step("R6", 1'b0, '0, 1'b1, 1'b1, 20'hFFFFF, 1'b0);
        step("R6", 1'b0, '0, 1'b1, 1'b1, 20'hFFFFF, 1'b0);
        step("R6", 1'b0, '0, 1'b0, 1'b0, 20'hFFFFF, 1'b0);

        // R8: carry chain and sum output
        load(pack(16'h6666, 16'h6666, 16'h6666, 16'h6666, 2'd1, 1'b0, 1'b0, 1'b0));
        for (int k = 0; k < 24; k++) begin
            logic [19:0] r = rnd();
            step("R8", 1'b0, '0, 1'b1, 1'b0, r, r[19] ^ r[7]);
        end
        step("R8", 1'b0, '0, 1'b1, 1'b0, 20'hFFFFF, 1'b1);
        step("R8", 1'b0, '0, 1'b1, 1'b0, 20'h00000, 1'b0);
        step("R8", 1'b0, '0, 1'b1, 1'b0, 20'h00000, 1'b1);
        load(pack(16'h6666, 16'h6666, 16'h6666, 16'h6666, 2'd3, 1'b0, 1'b0, 1'b0));
        for (int k = 0; k < 8; k++) step("R8", 1'b0, '0, 1'b1, 1'b0, rnd(), k[1]);

        // R9: cascade of four AND4 lookups
        load(pack(16'h8000, 16'h8000, 16'h8000, 16'h8000, 2'd3, 1'b0, 1'b0, 1'b1));
        step("R9", 1'b0, '0, 1'b1, 1'b0, 20'hFFFFF, 1'b1);
        step("R9", 1'b0, '0, 1'b1, 1'b0, 20'hFFFFF, 1'b0);
        for (int c = 0; c < N; c++)
            step("R9", 1'b0, '0, 1'b1, 1'b0, 20'hFFFFF & ~(20'h1 << (c*5 + 2)), 1'b1);
        for (int k = 0; k < 8; k++) step("R9", 1'b0, '0, 1'b1, 1'b0, rnd() | 20'h7BDEF, 1'b1);

        // R10: pair functions
        load(pack(16'hF0F0, 16'hCCCC, 16'hAAAA, 16'hFF00, 2'd2, 1'b0, 1'b0, 1'b0));
        for (int k = 0; k < 16; k++) step("R10", 1'b0, '0, 1'b1, 1'b0, rnd(), 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule